// File: doc/BRIEF.md
# Dual-Issue Register File

This block is the general-purpose register file for an in-order core that issues two instructions per cycle, called slot A and slot B. It holds 32 registers of 32 bits. Each slot reads two source operands and may write one result, so the file offers four combinational read ports and two clocked write ports. Each write port has its own enable, address and data.

A value written in a cycle is visible to all four read ports in that same cycle, so the decode stage needs no separate bypass path for results retiring at the same edge. When both slots target the same register, slot B is treated as the younger instruction. Its value is stored, and its value is the one the bypass returns. Register 0 is hard-wired to zero. An active-low asynchronous reset clears every register.

The read and write ports are plain per-cycle signals. There is no valid/ready handshake, because a read never stalls and a write always completes at the next rising clock edge.

Top module: `dual_issue_regfile`

## Requirements
- R1: The file holds 32 registers of 32 bits each. Read addresses are 5 bits wide, and each of the four read ports combinationally returns the value stored at its address when no write targets that address.
- R2: A write port with its enable high stores its data into the addressed register at the rising clock edge. The new value is visible on every read port from the next cycle on.
- R3: Both write ports may write two different registers in the same cycle, and both values are stored.
- R4: When both write ports are enabled with the same non-zero address, the slot B data is stored and the slot A data is discarded.
- R5: A read port whose address matches an enabled slot A write, with no slot B write to that address in that cycle, returns the slot A write data in that same cycle.
- R6: A read port whose address matches an enabled slot B write returns the slot B write data in that same cycle, whether or not slot A also writes that address.
- R7: Address 0 reads as zero on every read port at all times, including in a cycle in which either slot writes address 0. Such writes store nothing.
- R8: While rst_n is low, every register is cleared to zero. The clear takes effect without waiting for a clock edge.
- R9: The four read ports are independent. They may read four different registers, or the same register, in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_src0_addr | input | 5 | Slot A first source address |
| a_src0_data | output | 32 | Slot A first source value |
| a_src1_addr | input | 5 | Slot A second source address |
| a_src1_data | output | 32 | Slot A second source value |
| b_src0_addr | input | 5 | Slot B first source address |
| b_src0_data | output | 32 | Slot B first source value |
| b_src1_addr | input | 5 | Slot B second source address |
| b_src1_data | output | 32 | Slot B second source value |
| a_wr_en | input | 1 | Slot A write enable |
| a_wr_addr | input | 5 | Slot A destination address |
| a_wr_data | input | 32 | Slot A result |
| b_wr_en | input | 1 | Slot B write enable |
| b_wr_addr | input | 5 | Slot B destination address |
| b_wr_data | input | 32 | Slot B result |

## Verification
The hardest situation to reach is a cycle in which both slots write the same register while a read port also selects that register. Uniform 5-bit addresses make this three-way coincidence rare. The stimulus therefore draws most addresses from a small pool of low registers, including register 0. That pool makes slot-on-slot collisions and same-cycle read hits frequent. Directed cycles cover the exact collision-plus-read case, a collision on register 0, and a reset that arrives after the file is full of data.

// File: rtl/dreg_pkg.sv
package dreg_pkg;
  localparam int unsigned RF_DEPTH_DEF = 32;
  localparam int unsigned RF_WIDTH_DEF = 32;
  localparam int unsigned RF_RDPORTS   = 4;

  // Where a read port takes its value from
  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_BYP_B = 2'd1,
    SRC_BYP_A = 2'd2,
    SRC_ARRAY = 2'd3
  } rd_src_e;
endpackage

// File: rtl/dreg_wr_arb.sv
module dreg_wr_arb #(
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW = $clog2(NREGS)
) (
  input  logic          a_en,
  input  logic [AW-1:0] a_addr,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic          a_eff,
  output logic          b_eff,
  output logic [NREGS-1:1] sel_a,
  output logic [NREGS-1:1] sel_b
);
  logic collide;

  // slot B is younger: on a shared destination slot A is dropped
  assign collide = b_en && (b_addr == a_addr);
  assign a_eff   = a_en && (a_addr != '0) && !collide;
  assign b_eff   = b_en && (b_addr != '0);

  for (genvar i = 1; i < NREGS; i++) begin : g_dec
    assign sel_a[i] = a_eff && (a_addr == AW'(i));
    assign sel_b[i] = b_eff && (b_addr == AW'(i));
  end
endmodule

// File: rtl/dreg_store.sv
module dreg_store #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREGS-1:1] sel_a,
  input  logic [NREGS-1:1] sel_b,
  input  logic [DW-1:0]    a_data,
  input  logic [DW-1:0]    b_data,
  output logic [DW-1:0]    q [NREGS]
);
  // entry 0 has no storage
  assign q[0] = '0;

  for (genvar i = 1; i < NREGS; i++) begin : g_reg
    logic [DW-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        r <= '0;
      else if (sel_b[i]) r <= b_data;
      else if (sel_a[i]) r <= a_data;
    end
    assign q[i] = r;
  end
endmodule

// File: rtl/dreg_rd_port.sv
module dreg_rd_port
  import dreg_pkg::*;
#(
  parameter int unsigned NREGS = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW = $clog2(NREGS)
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] q [NREGS],
  input  logic          a_eff,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_data,
  input  logic          b_eff,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_data,
  output logic [DW-1:0] data
);
  rd_src_e src;

  always_comb begin
    if (addr == '0)                       src = SRC_ZERO;
    else if (b_eff && (b_addr == addr))   src = SRC_BYP_B;
    else if (a_eff && (a_addr == addr))   src = SRC_BYP_A;
    else                                  src = SRC_ARRAY;
  end

  always_comb begin
    unique case (src)
      SRC_ZERO:  data = '0;
      SRC_BYP_B: data = b_data;
      SRC_BYP_A: data = a_data;
      default:   data = q[addr];
    endcase
  end
endmodule

// File: rtl/dual_issue_regfile.sv
module dual_issue_regfile
  import dreg_pkg::*;
#(
  parameter int unsigned NREGS = RF_DEPTH_DEF,
  parameter int unsigned DW    = RF_WIDTH_DEF,
  localparam int unsigned AW = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_src0_addr,
  output logic [DW-1:0] a_src0_data,
  input  logic [AW-1:0] a_src1_addr,
  output logic [DW-1:0] a_src1_data,
  input  logic [AW-1:0] b_src0_addr,
  output logic [DW-1:0] b_src0_data,
  input  logic [AW-1:0] b_src1_addr,
  output logic [DW-1:0] b_src1_data,
  input  logic          a_wr_en,
  input  logic [AW-1:0] a_wr_addr,
  input  logic [DW-1:0] a_wr_data,
  input  logic          b_wr_en,
  input  logic [AW-1:0] b_wr_addr,
  input  logic [DW-1:0] b_wr_data
);
  logic             a_eff, b_eff;
  logic [NREGS-1:1] sel_a, sel_b;
  logic [DW-1:0]    q [NREGS];
  logic [AW-1:0]    rd_addr_v [RF_RDPORTS];
  logic [DW-1:0]    rd_data_v [RF_RDPORTS];

  dreg_wr_arb #(.NREGS(NREGS)) arb_i (
    .a_en(a_wr_en), .a_addr(a_wr_addr),
    .b_en(b_wr_en), .b_addr(b_wr_addr),
    .a_eff(a_eff), .b_eff(b_eff),
    .sel_a(sel_a), .sel_b(sel_b)
  );

  dreg_store #(.NREGS(NREGS), .DW(DW)) store_i (
    .clk(clk), .rst_n(rst_n),
    .sel_a(sel_a), .sel_b(sel_b),
    .a_data(a_wr_data), .b_data(b_wr_data),
    .q(q)
  );

  assign rd_addr_v[0] = a_src0_addr;
  assign rd_addr_v[1] = a_src1_addr;
  assign rd_addr_v[2] = b_src0_addr;
  assign rd_addr_v[3] = b_src1_addr;

  for (genvar j = 0; j < RF_RDPORTS; j++) begin : g_rd
    dreg_rd_port #(.NREGS(NREGS), .DW(DW)) port_i (
      .addr(rd_addr_v[j]), .q(q),
      .a_eff(a_eff), .a_addr(a_wr_addr), .a_data(a_wr_data),
      .b_eff(b_eff), .b_addr(b_wr_addr), .b_data(b_wr_data),
      .data(rd_data_v[j])
    );
  end

  assign a_src0_data = rd_data_v[0];
  assign a_src1_data = rd_data_v[1];
  assign b_src0_data = rd_data_v[2];
  assign b_src1_data = rd_data_v[3];
endmodule

// File: rtl/dreg_chk.sv
module dreg_chk #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned NP    = 4,
  localparam int unsigned AW = $clog2(NREGS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] rd_addr [NP],
  input logic [DW-1:0] rd_data [NP],
  input logic          a_wr_en,
  input logic [AW-1:0] a_wr_addr,
  input logic [DW-1:0] a_wr_data,
  input logic          b_wr_en,
  input logic [AW-1:0] b_wr_addr,
  input logic [DW-1:0] b_wr_data
);
  for (genvar p = 0; p < NP; p++) begin : g_p
    logic hit_a, hit_b;
    assign hit_a = a_wr_en && (a_wr_addr == rd_addr[p]);
    assign hit_b = b_wr_en && (b_wr_addr == rd_addr[p]);

    // R7
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr[p] == '0) |-> (rd_data[p] == '0));

    // R6
    byp_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_b && rd_addr[p] != '0) |-> (rd_data[p] == b_wr_data));

    // R5
    byp_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_a && !hit_b && rd_addr[p] != '0) |-> (rd_data[p] == a_wr_data));

    // R2
    persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_wr_en && b_wr_addr != '0) ##1
      (rd_addr[p] == $past(b_wr_addr) && !hit_a && !hit_b)
      |-> (rd_data[p] == $past(b_wr_data)));

    // R4
    collide_keep_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr_en && b_wr_en && a_wr_addr == b_wr_addr && b_wr_addr != '0) ##1
      (rd_addr[p] == $past(b_wr_addr) && !hit_a && !hit_b)
      |-> (rd_data[p] == $past(b_wr_data)));
  end
endmodule

bind dual_issue_regfile dreg_chk #(.NREGS(NREGS), .DW(DW), .NP(dreg_pkg::RF_RDPORTS)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .rd_addr(rd_addr_v), .rd_data(rd_data_v),
  .a_wr_en(a_wr_en), .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
  .b_wr_en(b_wr_en), .b_wr_addr(b_wr_addr), .b_wr_data(b_wr_data)
);

// File: tb/dual_issue_regfile_tb_top.sv
module dual_issue_regfile_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 0, rst_n = 0;
  logic [4:0]  ra [4];
  logic [31:0] rd [4];
  logic a_we = 0, b_we = 0;
  logic [4:0] a_wa = 0, b_wa = 0;
  logic [31:0] a_wd = 0, b_wd = 0;
  logic [31:0] model [N];
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_src0_addr(ra[0]), .a_src0_data(rd[0]),
    .a_src1_addr(ra[1]), .a_src1_data(rd[1]),
    .b_src0_addr(ra[2]), .b_src0_data(rd[2]),
    .b_src1_addr(ra[3]), .b_src1_data(rd[3]),
    .a_wr_en(a_we), .a_wr_addr(a_wa), .a_wr_data(a_wd),
    .b_wr_en(b_we), .b_wr_addr(b_wa), .b_wr_data(b_wd)
  );

  function automatic logic [31:0] exp_read(logic [4:0] adr);
    if (adr == 0) return 32'h0;
    if (b_we && b_wa == adr) return b_wd;
    if (a_we && a_wa == adr) return a_wd;
    return model[adr];
  endfunction

  function automatic string tag_of(logic [4:0] adr);
    if (adr == 0) return "R7";
    if (b_we && b_wa == adr) return "R6";
    if (a_we && a_wa == adr) return "R5";
    return "R2";
  endfunction

  task automatic check_ports(string forced);
    for (int p = 0; p < 4; p++) begin
      logic [31:0] e;
      string t;
      e = exp_read(ra[p]);
      t = (forced != "") ? forced : tag_of(ra[p]);
      n_checks++;
      if (rd[p] !== e) begin
        n_fail++;
        $display("FAIL %s port %0d addr %0d: actual %h expected %h", t, p, ra[p], rd[p], e);
      end
    end
  endtask

  // inputs are set just after a falling edge; check, then let the rising edge commit
  task automatic cycle(string forced);
    #1;
    check_ports(forced);
    @(posedge clk);
    if (rst_n) begin
      if (a_we && a_wa != 0) model[a_wa] = a_wd;
      if (b_we && b_wa != 0) model[b_wa] = b_wd;  // R4: B last wins
    end
    @(negedge clk);
  endtask

  function automatic logic [4:0] pick_addr();
    if ($urandom_range(0, 3) != 0) return 5'($urandom_range(0, 5));
    return 5'($urandom_range(0, 31));
  endfunction

  initial begin
    void'($urandom(32'h5EED_2B1D));
    for (int i = 0; i < N; i++) model[i] = 0;
    for (int p = 0; p < 4; p++) ra[p] = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R8 / R1: reset state across the whole file, R9 four distinct addresses
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 4; p++) ra[p] = 5'(k*4 + p);
      cycle("R8");
    end

    // R3: two different registers in one cycle
    a_we = 1; a_wa = 3; a_wd = 32'hAAAA_0003;
    b_we = 1; b_wa = 4; b_wd = 32'hBBBB_0004;
    ra[0] = 7; ra[1] = 8; ra[2] = 9; ra[3] = 10;
    cycle("R3");
    a_we = 0; b_we = 0;
    ra[0] = 3; ra[1] = 4; ra[2] = 3; ra[3] = 4;
    cycle("R3");

    // R4 + R6: collision while every port reads that register
    a_we = 1; a_wa = 5; a_wd = 32'h1111_1111;
    b_we = 1; b_wa = 5; b_wd = 32'h2222_2222;
    for (int p = 0; p < 4; p++) ra[p] = 5;
    cycle("R6");
    a_we = 0; b_we = 0;
    cycle("R4");

    // R5: slot A write bypass alone
    a_we = 1; a_wa = 6; a_wd = 32'hCAFE_0006;
    ra[0] = 6; ra[1] = 0; ra[2] = 6; ra[3] = 5;
    cycle("R5");
    a_we = 0;

    // R7: both slots write register 0, read it in that cycle and the next
    a_we = 1; a_wa = 0; a_wd = 32'hDEAD_BEEF;
    b_we = 1; b_wa = 0; b_wd = 32'hFEED_F00D;
    for (int p = 0; p < 4; p++) ra[p] = 0;
    cycle("R7");
    a_we = 0; b_we = 0;
    cycle("R7");

    // random mix, R9 independent ports
    for (int it = 0; it < 3000; it++) begin
      a_we = 1'($urandom_range(0, 1)); a_wa = pick_addr(); a_wd = $urandom();
      b_we = 1'($urandom_range(0, 1)); b_wa = pick_addr(); b_wd = $urandom();
      if ($urandom_range(0, 7) == 0) b_wa = a_wa;
      for (int p = 0; p < 4; p++) ra[p] = pick_addr();
      cycle("");
    end

    // R8: asynchronous clear of a populated file
    a_we = 0; b_we = 0;
    for (int i = 1; i < N; i++) begin
      a_we = 1; a_wa = 5'(i); a_wd = 32'h100 + i;
      cycle("");
    end
    a_we = 0;
    #2 rst_n = 0;
    for (int i = 0; i < N; i++) model[i] = 0;
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 4; p++) ra[p] = 5'(k*4 + p);
      #1 check_ports("R8");
    end
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule